// File: doc/BRIEF.md
# Dual Timer/Counter Pair with Split Mode

This block holds two up-counting timer/counters. Each counter is a pair of bytes, a low byte and a high byte. Software loads and reads these bytes through a small register port. Each counter steps by one in a cycle where it is enabled. A counter is enabled when its run bit is set and its gate allows counting. The step source is then either the machine-cycle strobe `tick` or that counter's one-cycle external pulse input, picked by its source-select bit.

A two-bit mode field for each counter selects one of four layouts:

| Code | Layout |
|------|--------|
| 0 | 13-bit prescaled count |
| 1 | Full 16-bit count |
| 2 | 8-bit count with automatic reload |
| 3 | Split |

In split mode, counter 0 becomes two independent 8-bit counters. The low byte keeps counter 0's controls and sets counter 0's overflow flag. The high byte counts machine cycles whenever counter 1's run bit is set, and its wrap sets counter 1's overflow flag. Each overflow flag stays set until it is cleared through its clear input. The flags are the block's only event outputs. Interrupt vectoring and baud-rate generation sit outside the block.

All inputs are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. A register write is accepted in the cycle it is presented.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all four counter bytes read 0x00 and both overflow flags read 0.
- R2: Register address 0 selects counter 0's low byte, 1 selects counter 0's high byte, 2 selects counter 1's low byte and 3 selects counter 1's high byte. A write takes effect at the next clock edge and takes precedence over counting for the byte written. `rd_data` shows the addressed byte combinationally.
- R3: With `ext_sel[i]`=0, counter i steps once in each cycle where `tick` is high. With `ext_sel[i]`=1, it steps once in each cycle where `ext_pulse[i]` is high, and `tick` is ignored.
- R4: With `run[i]`=0, counter i does not change except by register writes.
- R5: With `gate_en[i]`=1, counter i steps only in cycles where `gate_in[i]` is high. With `gate_en[i]`=0, `gate_in[i]` has no effect.
- R6: Mode 0 (13-bit) works as follows:
  - Bits 4:0 of the low byte count. A carry out of bit 4 increments the high byte.
  - Bits 7:5 of the low byte keep their value.
  - Stepping from high byte 0xFF with low bits 0x1F sets the flag.
- R7: In mode 1 (16-bit), stepping from 0xFFFF yields 0x0000 and sets the counter's flag.
- R8: In mode 2 (auto-reload), the low byte counts. When it steps from 0xFF, it loads the high byte's value in the same edge and sets the flag. The high byte is unchanged.
- R9: With counter 0 in mode 3, its low byte is an 8-bit counter under counter 0's run, gate and source controls. Stepping it from 0xFF gives 0x00 and sets flag 0.
- R10: With counter 0 in mode 3, its high byte steps on every `tick` while `run[1]`=1, ignoring `gate_en`, `gate_in` and `ext_sel`. Its wrap from 0xFF sets flag 1, and counter 1's own overflow does not set flag 1.
- R11: Counter 1 in mode 3 holds its value.
- R12: An overflow flag stays set until `ovf_clr[i]` is high at a clock edge. When a set and a clear coincide, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Byte selected for writing |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Byte selected for reading |
| rd_data | output | 8 | Selected byte value |
| t0_mode | input | 2 | Mode of counter 0 |
| t1_mode | input | 2 | Mode of counter 1 |
| run | input | 2 | Run bit per counter |
| gate_en | input | 2 | Gating enable per counter |
| gate_in | input | 2 | Gate level per counter |
| ext_sel | input | 2 | Step source select per counter (1 = external pulse) |
| tick | input | 1 | Machine-cycle strobe |
| ext_pulse | input | 2 | External count pulse per counter |
| ovf_clr | input | 2 | Overflow flag clear per counter |
| ovf | output | 2 | Overflow flag per counter |

## Verification
Each mode is tried with preloaded values just below its wrap point. This separates the last step before overflow from the overflow step itself, and it shows whether the 13-bit mode keeps the upper low-byte bits and carries at the 5-bit boundary. The source tests drive a steady `tick` and then sparse `ext_pulse` strobes with `tick` still high, so a counter that takes the wrong source shows a different count. The split-mode test wraps counter 1 and counter 0's high byte in different cycles, so it shows which one drives flag 1. It then closes the gates and selects the external source, which shows that the high byte ignores both controls. Flag tests hold the flag across idle cycles and also present a clear in the same cycle as a new overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_PRESCALE13 = 2'd0,
    TM_WIDE16     = 2'd1,
    TM_RELOAD8    = 2'd2,
    TM_SPLIT      = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_step_gen.sv
// Per-counter step enables from run, gate and source select.
module tmr_step_gen #(
  parameter int N = 2
) (
  input  logic         tick,
  input  logic [N-1:0] ext_pulse,
  input  logic [N-1:0] run,
  input  logic [N-1:0] gate_en,
  input  logic [N-1:0] gate_in,
  input  logic [N-1:0] ext_sel,
  output logic [N-1:0] step_en
);
  for (genvar i = 0; i < N; i++) begin : g_en
    logic src;
    logic allow;
    assign src        = ext_sel[i] ? ext_pulse[i] : tick;
    assign allow      = run[i] & (~gate_en[i] | gate_in[i]);
    assign step_en[i] = src & allow;
  end
endmodule

// File: rtl/tmr_flags.sv
// Sticky overflow flags; a set wins over a simultaneous clear.
module tmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_core.sv
// One counter: two bytes, mode-dependent step, optional split high byte.
module tmr_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              hi_step_en,
  input  tmr_mode_e         mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_pulse,
  output logic              hi_wrap
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W:0] lo_sum, hi_sum;
  logic [WIDE_W:0] wide_sum;
  logic [PRE_W:0]  pre_sum;
  logic [BYTE_W-1:0] lo_d, hi_d;

  assign lo_sum   = {1'b0, lo_q} + (BYTE_W+1)'(1);
  assign hi_sum   = {1'b0, hi_q} + (BYTE_W+1)'(1);
  assign wide_sum = {1'b0, hi_q, lo_q} + (WIDE_W+1)'(1);
  assign pre_sum  = {1'b0, lo_q[PRE_W-1:0]} + (PRE_W+1)'(1);

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    ovf_pulse = 1'b0;
    hi_wrap   = 1'b0;
    if (step_en) begin
      unique case (mode)
        TM_PRESCALE13: begin
          lo_d[PRE_W-1:0] = pre_sum[PRE_W-1:0];
          if (pre_sum[PRE_W]) begin
            hi_d      = hi_sum[BYTE_W-1:0];
            ovf_pulse = hi_sum[BYTE_W];
          end
        end
        TM_WIDE16: begin
          {hi_d, lo_d} = wide_sum[WIDE_W-1:0];
          ovf_pulse    = wide_sum[WIDE_W];
        end
        TM_RELOAD8: begin
          ovf_pulse = lo_sum[BYTE_W];
          lo_d      = lo_sum[BYTE_W] ? hi_q : lo_sum[BYTE_W-1:0];
        end
        TM_SPLIT: begin
          if (HAS_SPLIT) begin
            lo_d      = lo_sum[BYTE_W-1:0];
            ovf_pulse = lo_sum[BYTE_W];
          end
        end
        default: ;
      endcase
    end
    if (HAS_SPLIT && mode == TM_SPLIT && hi_step_en) begin
      hi_d    = hi_sum[BYTE_W-1:0];
      hi_wrap = hi_sum[BYTE_W];
    end
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [1:0]        t0_mode,
  input  logic [1:0]        t1_mode,
  input  logic [1:0]        run,
  input  logic [1:0]        gate_en,
  input  logic [1:0]        gate_in,
  input  logic [1:0]        ext_sel,
  input  logic              tick,
  input  logic [1:0]        ext_pulse,
  input  logic [1:0]        ovf_clr,
  output logic [1:0]        ovf
);
  localparam int NT = 2;

  logic [NT-1:0]             step_en;
  logic [NT-1:0]             hi_step;
  logic [NT-1:0]             ovf_pulse;
  logic [NT-1:0]             hi_wrap;
  logic [NT-1:0]             flag_set;
  logic [NT-1:0][BYTE_W-1:0] lo_q;
  logic [NT-1:0][BYTE_W-1:0] hi_q;
  tmr_mode_e                 mode [NT];
  logic                      t0_split;

  assign mode[0]  = tmr_mode_e'(t0_mode);
  assign mode[1]  = tmr_mode_e'(t1_mode);
  assign t0_split = (mode[0] == TM_SPLIT);

  // Borrowed high byte of counter 0 runs on counter 1's run bit only.
  assign hi_step[0] = tick & run[1];
  assign hi_step[1] = 1'b0;

  tmr_step_gen #(.N(NT)) u_steps (
    .tick      (tick),
    .ext_pulse (ext_pulse),
    .run       (run),
    .gate_en   (gate_en),
    .gate_in   (gate_in),
    .ext_sel   (ext_sel),
    .step_en   (step_en)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_core #(
      .BYTE_W    (BYTE_W),
      .PRE_W     (PRE_W),
      .HAS_SPLIT (i == 0)
    ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en[i]),
      .hi_step_en (hi_step[i]),
      .mode       (mode[i]),
      .wr_lo      (wr_en && wr_addr == 2'(2*i)),
      .wr_hi      (wr_en && wr_addr == 2'(2*i+1)),
      .wr_data    (wr_data),
      .lo_q       (lo_q[i]),
      .hi_q       (hi_q[i]),
      .ovf_pulse  (ovf_pulse[i]),
      .hi_wrap    (hi_wrap[i])
    );
  end

  assign flag_set[0] = ovf_pulse[0];
  assign flag_set[1] = t0_split ? hi_wrap[0] : (ovf_pulse[1] | hi_wrap[1]);

  tmr_flags #(.N(NT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (ovf_clr),
    .flag_q (ovf)
  );

  always_comb begin
    unique case (rd_addr)
      2'd0:    rd_data = lo_q[0];
      2'd1:    rd_data = hi_q[0];
      2'd2:    rd_data = lo_q[1];
      default: rd_data = hi_q[1];
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int BYTE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [1:0]             t0_mode,
  input logic [1:0]             t1_mode,
  input logic [1:0]             run,
  input logic [1:0]             gate_en,
  input logic [1:0]             gate_in,
  input logic [1:0]             ext_sel,
  input logic                   tick,
  input logic [1:0]             ext_pulse,
  input logic [1:0]             ovf_clr,
  input logic [1:0]             ovf,
  input logic [1:0][BYTE_W-1:0] lo_q,
  input logic [1:0][BYTE_W-1:0] hi_q
);
  logic en0;
  assign en0 = run[0] && (!gate_en[0] || gate_in[0]) &&
               (ext_sel[0] ? ext_pulse[0] : tick);

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[1] && !wr_en) |=> ($stable(lo_q[1]) && $stable(hi_q[1]))); // R4

  AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_mode == 2'd1 && en0 && lo_q[0] == '1 && hi_q[0] == '1 && !wr_en)
    |=> (lo_q[0] == '0 && hi_q[0] == '0 && ovf[0])); // R7

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_mode == 2'd2 && en0 && lo_q[0] == '1 && !wr_en)
    |=> (lo_q[0] == $past(hi_q[0]) && ovf[0])); // R8

  AST_SPLIT_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_mode == 2'd3 && !(run[1] && tick && hi_q[0] == '1) && !ovf[1])
    |=> !ovf[1]); // R10

  AST_T1_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_mode == 2'd3 && !wr_en) |=> ($stable(lo_q[1]) && $stable(hi_q[1]))); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !ovf_clr[0]) |=> ovf[0]); // R12
endmodule

bind tmr_pair tmr_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .t0_mode   (t0_mode),
  .t1_mode   (t1_mode),
  .run       (run),
  .gate_en   (gate_en),
  .gate_in   (gate_in),
  .ext_sel   (ext_sel),
  .tick      (tick),
  .ext_pulse (ext_pulse),
  .ovf_clr   (ovf_clr),
  .ovf       (ovf),
  .lo_q      (lo_q),
  .hi_q      (hi_q)
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] t0_mode = '0, t1_mode = '0;
  logic [1:0] run = '0, gate_en = '0, gate_in = '0, ext_sel = '0;
  logic       tick = 1'b0;
  logic [1:0] ext_pulse = '0, ovf_clr = '0;
  logic [1:0] ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_pair u0 (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycles(1);
    wr_en = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [1:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), int'(exp));
  endtask

  task automatic ticks(int n);
    tick = 1'b1; cycles(n); tick = 1'b0;
  endtask

  task automatic clear_all();
    run = '0; gate_en = '0; ext_sel = '0; tick = 1'b0;
    ovf_clr = 2'b11; cycles(1); ovf_clr = '0;
  endtask

  task automatic t_reset();
    chk_reg("R1 TL0", 2'd0, 8'h00);
    chk_reg("R1 TH0", 2'd1, 8'h00);
    chk_reg("R1 TL1", 2'd2, 8'h00);
    chk_reg("R1 TH1", 2'd3, 8'h00);
    check("R1 flags", int'(ovf), 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'h33); wr(2'd3, 8'h44);
    chk_reg("R2 TL0", 2'd0, 8'h11);
    chk_reg("R2 TH0", 2'd1, 8'h22);
    chk_reg("R2 TL1", 2'd2, 8'h33);
    chk_reg("R2 TH1", 2'd3, 8'h44);
  endtask

  task automatic t_run_hold();
    t0_mode = 2'd1; t1_mode = 2'd1; run = '0;
    ticks(5);
    chk_reg("R4 TL0 held", 2'd0, 8'h11);
    chk_reg("R4 TL1 held", 2'd2, 8'h33);
  endtask

  task automatic t_source();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    t0_mode = 2'd1; run = 2'b01; ext_sel = 2'b00;
    ticks(10);
    chk_reg("R3 tick source", 2'd0, 8'd10);
    ext_sel = 2'b01; tick = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ext_pulse[0] = (k % 3 == 0);
      cycles(1);
    end
    ext_pulse = '0; tick = 1'b0;
    chk_reg("R3 external source", 2'd0, 8'd13);
    clear_all();
  endtask

  task automatic t_gate();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    t0_mode = 2'd1; run = 2'b01; gate_en = 2'b01; gate_in = 2'b00;
    ticks(5);
    chk_reg("R5 gate closed", 2'd0, 8'd0);
    gate_in = 2'b01;
    ticks(4);
    chk_reg("R5 gate open", 2'd0, 8'd4);
    gate_en = 2'b00; gate_in = 2'b00;
    ticks(2);
    chk_reg("R5 gate disabled", 2'd0, 8'd6);
    clear_all();
  endtask

  task automatic t_mode13();
    t0_mode = 2'd0;
    wr(2'd0, 8'h1F); wr(2'd1, 8'h12);
    run = 2'b01; ticks(1);
    chk_reg("R6 low carry", 2'd0, 8'h00);
    chk_reg("R6 high inc", 2'd1, 8'h13);
    run = 2'b00;
    wr(2'd0, 8'hFD); wr(2'd1, 8'hFF);
    run = 2'b01; ticks(2);
    chk_reg("R6 upper bits kept", 2'd0, 8'hFF);
    check("R6 no flag yet", int'(ovf[0]), 0);
    ticks(1);
    chk_reg("R6 wrap low", 2'd0, 8'hE0);
    chk_reg("R6 wrap high", 2'd1, 8'h00);
    check("R6 flag", int'(ovf[0]), 1);
    clear_all();
  endtask

  task automatic t_mode16_flags();
    t0_mode = 2'd1;
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    run = 2'b01; ticks(1);
    check("R7 no flag at FFFF", int'(ovf[0]), 0);
    ticks(1);
    chk_reg("R7 low zero", 2'd0, 8'h00);
    chk_reg("R7 high zero", 2'd1, 8'h00);
    check("R7 flag", int'(ovf[0]), 1);
    cycles(3);
    check("R12 flag sticky", int'(ovf[0]), 1);
    ovf_clr = 2'b01; cycles(1); ovf_clr = '0;
    check("R12 flag cleared", int'(ovf[0]), 0);
    run = 2'b00;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    run = 2'b01; ovf_clr = 2'b01; ticks(1); ovf_clr = '0;
    check("R12 set beats clear", int'(ovf[0]), 1);
    clear_all();
  endtask

  task automatic t_reload();
    t0_mode = 2'd1; t1_mode = 2'd2;
    wr(2'd2, 8'hFE); wr(2'd3, 8'hF0);
    run = 2'b10; ticks(1);
    chk_reg("R8 before wrap", 2'd2, 8'hFF);
    check("R8 no flag", int'(ovf[1]), 0);
    ticks(1);
    chk_reg("R8 reloaded", 2'd2, 8'hF0);
    chk_reg("R8 high kept", 2'd3, 8'hF0);
    check("R8 flag", int'(ovf[1]), 1);
    clear_all();
  endtask

  task automatic t_split();
    t0_mode = 2'd3; t1_mode = 2'd1;
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFD); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    run = 2'b11; ticks(1);
    chk_reg("R9 low step", 2'd0, 8'hFF);
    chk_reg("R10 high step", 2'd1, 8'hFE);
    chk_reg("R10 t1 wrapped", 2'd2, 8'h00);
    check("R10 t1 wrap no flag", int'(ovf[1]), 0);
    ticks(1);
    chk_reg("R9 low wrap", 2'd0, 8'h00);
    check("R9 flag0", int'(ovf[0]), 1);
    check("R10 flag1 not yet", int'(ovf[1]), 0);
    ticks(1);
    chk_reg("R10 high wrap", 2'd1, 8'h00);
    check("R10 flag1", int'(ovf[1]), 1);
    ovf_clr = 2'b11; cycles(1); ovf_clr = '0;
    gate_en = 2'b11; gate_in = 2'b00; ext_sel = 2'b11;
    ticks(4);
    chk_reg("R9 low gated off", 2'd0, 8'h01);
    chk_reg("R10 high ignores gate/source", 2'd1, 8'h04);
    clear_all();
  endtask

  task automatic t_t1_parked();
    t0_mode = 2'd1; t1_mode = 2'd3;
    wr(2'd2, 8'h5A); wr(2'd3, 8'hA5);
    run = 2'b10; ticks(6);
    chk_reg("R11 TL1 held", 2'd2, 8'h5A);
    chk_reg("R11 TH1 held", 2'd3, 8'hA5);
    clear_all();
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_regs();
    t_run_hold();
    t_source();
    t_gate();
    t_mode13();
    t_mode16_flags();
    t_reload();
    t_split();
    t_t1_parked();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule